// File: doc/BRIEF.md
# Rate-Half Convolutional Encoder

This block turns a serial stream of data bits into a coded stream carrying two bits for every bit it takes in. Its memory is a two-stage shift register holding the two most recent accepted bits. Two modulo-2 parity networks combine the current bit with that memory. The first coded bit is x(t)⊕x(t-1)⊕x(t-2) and the second is x(t)⊕x(t-2). The result is an encoder with four states and a fixed transition and output table.

Every accepted bit yields the coded pair on a registered two-bit parallel output with its own valid flag. When serial mode is selected, a parallel-to-serial stage also sends the same pair on one line, first bit before second. While the second bit is on the line, the encoder stops taking input. The generator taps, the constraint length and the number of coded bits are parameters. The defaults give the rate-half, four-state code described here.

Top module: `conv_enc_r2`

## Requirements
- R1: While `rst_n` is low, and after it is released, the encoder state is 00, `par_valid` and `ser_valid` are 0 and `in_ready` is 1. The first bit accepted after reset is coded from state 00: 0 gives `par_out` 00 and 1 gives 11.
- R2: A bit is accepted on a rising clock edge where `in_valid` and `in_ready` are both 1. Only then does the state (x(t-1), x(t-2)) move to (accepted bit, old x(t-1)).
- R3: On edges with no accepted bit, `par_valid` goes to 0, `par_out` and the state hold, and `ser_valid` stays 0 while the serializer is idle.
- R4: `par_valid` is 1 for exactly the one cycle after each edge that accepts a bit.
- R5: `par_out[1]` = x(t)⊕x(t-1)⊕x(t-2) and `par_out[0]` = x(t)⊕x(t-2). From state (x(t-1),x(t-2)) = 00, 01, 10, 11, input 0 gives 00, 11, 10, 01 and input 1 gives 11, 00, 01, 10.
- R6: With `ser_mode` = 1, in the cycle a bit is offered and accepted, `ser_valid` is 1 and `ser_out` shows the first coded bit. In the next cycle `ser_valid` is 1, `ser_out` shows the second coded bit, and `in_ready` is 0.
- R7: With `ser_mode` = 0, `in_ready` stays 1 and `ser_valid` stays 0, so one bit can be accepted on every cycle.
- R8: A bit offered while `in_ready` is 0 is ignored. `ser_out` keeps showing the second coded bit, and the next accepted bit is coded from the state left by the last accepted bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| ser_mode | input | 1 | 1 selects serialized output with input throttling |
| in_valid | input | 1 | Data bit offered |
| in_bit | input | 1 | Data bit |
| in_ready | output | 1 | Encoder can accept a bit this cycle |
| par_out | output | NOUT (2) | Coded pair, bit 1 is the first coded bit |
| par_valid | output | 1 | `par_out` holds a fresh pair |
| ser_out | output | 1 | Serialized coded bit |
| ser_valid | output | 1 | `ser_out` carries a coded bit |

## Verification
The bench builds the encoder with its defaults: constraint length 3, two coded bits, and taps 111 and 101. With these values there are only eight state and input combinations. The bench feeds every 8-bit pattern back to back, first in parallel mode and then in serial mode. This reaches each transition many times from every preceding history, and each expected pair is computed from two bench-held history bits. In serial mode, the bench offers the inverted bit during every throttled cycle to show that it is refused. A reset is also applied in the middle of a stream.

// File: rtl/conv_enc_pkg.sv
package conv_enc_pkg;
  // Default code: constraint length 3, two coded bits per data bit.
  localparam int unsigned CE_K    = 3;
  localparam int unsigned CE_NOUT = 2;
  // Tap vector per coded bit, bit k weights x(t-k); upper slice is the first bit.
  localparam logic [CE_NOUT*CE_K-1:0] CE_GENS = {3'b111, 3'b101};
endpackage

// File: rtl/conv_enc_rst_sync.sv
module conv_enc_rst_sync (
  input  logic clk,
  input  logic arst_n,
  output logic rst_n_sync
);
  logic [1:0] sync_q;
  logic [1:0] sync_d;

  always_comb sync_d = {sync_q[0], 1'b1};

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) sync_q <= '0;
    else         sync_q <= sync_d;
  end

  assign rst_n_sync = sync_q[1];
endmodule

// File: rtl/conv_enc_state.sv
module conv_enc_state #(
  parameter int unsigned MEM = 2
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           adv,
  input  logic           din,
  output logic [MEM-1:0] state
);
  // state[0] = x(t-1), state[MEM-1] = oldest bit held
  logic [MEM:0]   win;
  logic [MEM-1:0] state_d;

  assign win = {state, din};

  always_comb begin
    state_d = state;
    if (adv) state_d = win[MEM-1:0];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state <= '0;
    else        state <= state_d;
  end

  AST_STATE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !adv |=> $stable(state)); // R3
  AST_STATE_SHIFT: assert property (@(posedge clk) disable iff (!rst_n)
    adv |=> (state[0] == $past(din))); // R2
endmodule

// File: rtl/conv_enc_parity.sv
module conv_enc_parity #(
  parameter int unsigned K    = 3,
  parameter int unsigned NOUT = 2,
  parameter logic [NOUT*K-1:0] GENS = {3'b111, 3'b101}
) (
  input  logic [K-1:0]    win,
  output logic [NOUT-1:0] code
);
  for (genvar i = 0; i < NOUT; i++) begin : g_net
    assign code[i] = ^(win & GENS[i*K +: K]);
  end
endmodule

// File: rtl/conv_enc_p2s.sv
module conv_enc_p2s #(
  parameter int unsigned NOUT = 2
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            load,
  input  logic [NOUT-1:0] pair,
  output logic            ser_out,
  output logic            ser_valid,
  output logic            busy
);
  localparam int unsigned CW = (NOUT > 2) ? $clog2(NOUT) : 1;
  localparam int unsigned SW = NOUT - 1;

  logic [CW-1:0] cnt_q, cnt_d;
  logic [SW-1:0] sh_q, sh_d;

  assign busy      = (cnt_q != '0);
  assign ser_valid = busy | load;
  assign ser_out   = busy ? sh_q[SW-1] : pair[NOUT-1];

  always_comb begin
    cnt_d = cnt_q;
    sh_d  = sh_q;
    if (load) begin
      cnt_d = CW'(NOUT - 1);
      sh_d  = pair[SW-1:0];
    end else if (busy) begin
      cnt_d = cnt_q - CW'(1);
      sh_d  = sh_q << 1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      sh_q  <= '0;
    end else begin
      cnt_q <= cnt_d;
      sh_q  <= sh_d;
    end
  end

  AST_LOAD_WHEN_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    load |-> !busy); // R8
  AST_LOAD_STARTS_TAIL: assert property (@(posedge clk) disable iff (!rst_n)
    load |=> (busy && ser_valid)); // R6
  AST_TAIL_BIT: assert property (@(posedge clk) disable iff (!rst_n)
    load |=> (ser_out == $past(pair[SW-1]))); // R6
  AST_TAIL_ENDS: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && cnt_q == CW'(1) && !load) |=> !busy); // R6
endmodule

// File: rtl/conv_enc_r2.sv
module conv_enc_r2 #(
  parameter int unsigned K    = conv_enc_pkg::CE_K,
  parameter int unsigned NOUT = conv_enc_pkg::CE_NOUT,
  parameter logic [NOUT*K-1:0] GENS = conv_enc_pkg::CE_GENS
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            ser_mode,
  input  logic            in_valid,
  input  logic            in_bit,
  output logic            in_ready,
  output logic [NOUT-1:0] par_out,
  output logic            par_valid,
  output logic            ser_out,
  output logic            ser_valid
);
  localparam int unsigned MEM = K - 1;

  logic           rst_ns;
  logic           accept;
  logic           busy;
  logic [MEM-1:0] state;
  logic [K-1:0]   win;
  logic [NOUT-1:0] code;
  logic [NOUT-1:0] par_out_d;
  logic            par_valid_d;

  conv_enc_rst_sync u_rst (
    .clk        (clk),
    .arst_n     (rst_n),
    .rst_n_sync (rst_ns)
  );

  assign in_ready = !busy;
  assign accept   = in_valid & in_ready;
  assign win      = {state, in_bit};

  conv_enc_state #(.MEM(MEM)) u_state (
    .clk   (clk),
    .rst_n (rst_ns),
    .adv   (accept),
    .din   (in_bit),
    .state (state)
  );

  conv_enc_parity #(.K(K), .NOUT(NOUT), .GENS(GENS)) u_parity (
    .win  (win),
    .code (code)
  );

  conv_enc_p2s #(.NOUT(NOUT)) u_p2s (
    .clk       (clk),
    .rst_n     (rst_ns),
    .load      (accept & ser_mode),
    .pair      (code),
    .ser_out   (ser_out),
    .ser_valid (ser_valid),
    .busy      (busy)
  );

  always_comb begin
    par_out_d   = par_out;
    par_valid_d = accept;
    if (accept) par_out_d = code;
  end

  always_ff @(posedge clk or negedge rst_ns) begin
    if (!rst_ns) begin
      par_out   <= '0;
      par_valid <= 1'b0;
    end else begin
      par_out   <= par_out_d;
      par_valid <= par_valid_d;
    end
  end

  AST_PAR_AFTER_ACCEPT: assert property (@(posedge clk) disable iff (!rst_ns)
    accept |=> par_valid); // R4
  AST_PAR_QUIET: assert property (@(posedge clk) disable iff (!rst_ns)
    !accept |=> (!par_valid && $stable(par_out))); // R3
  AST_SER_THROTTLE: assert property (@(posedge clk) disable iff (!rst_ns)
    (accept && ser_mode) |=> !in_ready); // R6
  AST_PAR_MODE_OPEN: assert property (@(posedge clk) disable iff (!rst_ns)
    (!ser_mode && in_ready) |=> (in_ready && !$rose(ser_valid))); // R7
endmodule

// File: tb/conv_enc_r2_bench.sv
module conv_enc_r2_bench;
  logic       clk;
  logic       rst_n;
  logic       ser_mode;
  logic       in_valid;
  logic       in_bit;
  logic       in_ready;
  logic [1:0] par_out;
  logic       par_valid;
  logic       ser_out;
  logic       ser_valid;

  int vectors = 0;
  int fails   = 0;
  logic m1 = 1'b0;  // x(t-1) in the bench model
  logic m2 = 1'b0;  // x(t-2) in the bench model

  conv_enc_r2 u_conv_enc_r2 (
    .clk       (clk),
    .rst_n     (rst_n),
    .ser_mode  (ser_mode),
    .in_valid  (in_valid),
    .in_bit    (in_bit),
    .in_ready  (in_ready),
    .par_out   (par_out),
    .par_valid (par_valid),
    .ser_out   (ser_out),
    .ser_valid (ser_valid)
  );

  initial clk = 1'b0;
  always #2 clk = ~clk;

  task automatic chk(input string req, input logic [1:0] act, input logic [1:0] exp);
    vectors++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %b expected %b", req, act, exp);
    end
  endtask

  task automatic summary();
    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0;
    in_valid = 1'b0;
    #1;
    chk("R1 ready in reset", {1'b0, in_ready}, 2'b01);
    chk("R1 valids in reset", {par_valid, ser_valid}, 2'b00);
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(posedge clk);
    #1;
    chk("R1 ready after release", {1'b0, in_ready}, 2'b01);
    chk("R1 valids after release", {par_valid, ser_valid}, 2'b00);
    m1 = 1'b0;
    m2 = 1'b0;
  endtask

  task automatic send_par(input logic b);
    logic [1:0] exp;
    @(negedge clk);
    in_valid = 1'b1;
    in_bit = b;
    #1;
    chk("R7 ready in parallel mode", {1'b0, in_ready}, 2'b01);
    chk("R7 serial line idle", {1'b0, ser_valid}, 2'b00);
    exp = {b ^ m1 ^ m2, b ^ m2};
    @(posedge clk);
    #1;
    chk("R5 coded pair", par_out, exp);
    chk("R4 pair valid", {1'b0, par_valid}, 2'b01);
    m2 = m1;
    m1 = b;
  endtask

  task automatic send_ser(input logic b);
    logic [1:0] exp;
    exp = {b ^ m1 ^ m2, b ^ m2};
    @(negedge clk);
    in_valid = 1'b1;
    in_bit = b;
    #1;
    chk("R6 first bit", {ser_valid, ser_out}, {1'b1, exp[1]});
    chk("R6 ready before accept", {1'b0, in_ready}, 2'b01);
    @(posedge clk);
    #1;
    chk("R6 second bit", {ser_valid, ser_out}, {1'b1, exp[0]});
    chk("R6 throttled", {1'b0, in_ready}, 2'b00);
    chk("R5 coded pair serial mode", par_out, exp);
    m2 = m1;
    m1 = b;
    @(negedge clk);
    in_bit = ~b;  // offered while throttled: must be refused
    #1;
    chk("R8 second bit holds", {ser_valid, ser_out}, {1'b1, exp[0]});
    chk("R8 still throttled", {1'b0, in_ready}, 2'b00);
    @(posedge clk);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    summary();
    $finish;
  end

  initial begin
    rst_n = 1'b0;
    ser_mode = 1'b0;
    in_valid = 1'b0;
    in_bit = 1'b0;
    do_reset();

    // Parallel mode, every 8-bit pattern back to back (R5, R4, R7)
    for (int v = 0; v < 256; v++)
      for (int k = 0; k < 8; k++)
        send_par(v[k]);

    // Idle cycles with in_bit toggling: nothing moves (R3, R2)
    begin
      logic [1:0] hold;
      @(negedge clk);
      in_valid = 1'b0;
      @(posedge clk);
      #1;
      hold = par_out;
      for (int i = 0; i < 4; i++) begin
        @(negedge clk);
        in_bit = i[0];
        @(posedge clk);
        #1;
        chk("R3 no valid when idle", {par_valid, ser_valid}, 2'b00);
        chk("R3 pair held", par_out, hold);
      end
    end
    send_par(1'b0);  // coded from pre-idle state: R2 advance only on accept
    send_par(1'b1);

    // Serial mode, every 8-bit pattern (R6, R8)
    @(negedge clk);
    in_valid = 1'b0;
    ser_mode = 1'b1;
    for (int v = 0; v < 256; v++)
      for (int k = 0; k < 8; k++)
        send_ser(v[k]);

    // Reset in mid-stream, then code from state 00 (R1)
    @(negedge clk);
    in_valid = 1'b0;
    ser_mode = 1'b0;
    send_par(1'b1);
    send_par(1'b1);
    do_reset();
    send_par(1'b0);
    chk("R1 first after reset is 00", par_out, 2'b00);
    send_par(1'b1);
    chk("R1 then 1 gives 11", par_out, 2'b11);

    @(negedge clk);
    in_valid = 1'b0;
    summary();
    $finish;
  end
endmodule